// File: doc/BRIEF.md
# Alignment-Fault Context Frame Writer

When a word or long access lands on an odd effective address, the processor must save enough context for a handler to find out what went wrong. This block does that save. It takes a start pulse with the program counter, the status register, the opcode word and the full 32-bit faulting address, and it takes the supervisor stack pointer. It then stores seven 16-bit words below that stack pointer, one bus write at a time. Each write waits for an acknowledge. When the frame is complete, the block reports the lowered stack pointer and pulses a completion flag.

The store order is fixed and does not descend steadily. With a starting stack pointer S, the seven writes go to S-2, S-6, S-4, S-8, S-10, S-14 and S-12, in that order. The opcode word is written twice, at S-8 and at S-10. The faulting address is stored as a full 32-bit sum and is not cut down to the bus width. The neighbouring logic decides when a fault has happened. It also fetches the handler vector and reloads the program counter afterwards.

Top module: `addr_fault_frame_seq`

## Requirements
- R1: While rst is high and on the first cycle after rst falls, wr_en_o is 0, done_o is 0 and ssp_o is 0. A reset during a sequence abandons it.
- R2: A start_i pulse while idle launches exactly seven writes. With S the sampled ssp_i, wr_addr_o takes the values S-2, S-6, S-4, S-8, S-10, S-14, S-12 in that order. The first write is presented in the cycle after start_i is sampled.
- R3: The word written goes to an address that depends on its source:
  - PC bits 15:0 go to S-2.
  - PC bits 31:16 go to S-4.
  - The status register goes to S-6.
  - The opcode word goes to both S-8 and S-10.
  - Fault address bits 15:0 go to S-14.
  - Fault address bits 31:16 go to S-12.
- R4: While wr_en_o is 1 and wr_ack_i is 0, the write does not advance, and wr_addr_o and wr_data_o hold their values.
- R5: done_o is 1 for exactly one cycle, namely the cycle after the seventh acknowledge is sampled. wr_en_o is 0 in that cycle.
- R6: From the done_o cycle onward, ssp_o equals S-14. It keeps that value until another frame completes or a reset occurs.
- R7: All inputs are sampled on the start cycle. Changes to pc_i, sr_i, ir_i, fault_addr_i or ssp_i during a sequence have no effect. A start_i pulse during a sequence neither restarts it nor queues a second one.
- R8: Address arithmetic wraps modulo 2^SP_W when S is smaller than 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Fault detected, begin saving the frame |
| pc_i | input | 32 | Program counter to save |
| sr_i | input | 16 | Status register value from before the fault |
| ir_i | input | 16 | Opcode word of the faulting instruction |
| fault_addr_i | input | 32 | Full 32-bit faulting effective address |
| ssp_i | input | SP_W | Supervisor stack pointer on entry |
| wr_ack_i | input | 1 | Bus acknowledge for the current write |
| wr_en_o | output | 1 | A word write is being requested |
| wr_addr_o | output | SP_W | Byte address of the word write |
| wr_data_o | output | 16 | Data of the word write |
| ssp_o | output | SP_W | Stack pointer after the frame has been stored |
| done_o | output | 1 | One-cycle pulse marking the end of the frame |

## Verification
The bench builds the block with its default stack pointer width of 32 bits. At that width the worked trace can be replayed word for word: S = 0x4542AC, PC = 0x0070C606, SR = 0x2313, opcode = 0xDBB3 and fault address 0xE0368B61. The full 32-bit width also lets a stack pointer of 6 push the frame across the top of the 32-bit address space, which is the wrap case of R8. The tests use several acknowledge delay patterns, change the inputs and pulse start in the middle of a frame, and reset in the middle of a frame.

// File: rtl/afs_pkg.sv
`timescale 1ns/1ps
package afs_pkg;

    localparam int FRAME_WORDS = 7;
    localparam int FRAME_BYTES = 2 * FRAME_WORDS;
    localparam int STEP_W      = $clog2(FRAME_WORDS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_PC_LO,
        SRC_PC_HI,
        SRC_SR,
        SRC_IR,
        SRC_FA_LO,
        SRC_FA_HI
    } word_src_e;

    typedef struct packed {
        logic [31:0] pc;
        logic [15:0] sr;
        logic [15:0] ir;
        logic [31:0] fault;
    } frame_ctx_t;

    // Byte distance below the entry stack pointer for each bus step.
    function automatic logic [3:0] slot_offset(input logic [STEP_W-1:0] step);
        case (step)
            3'd0:    return 4'd2;
            3'd1:    return 4'd6;
            3'd2:    return 4'd4;
            3'd3:    return 4'd8;
            3'd4:    return 4'd10;
            3'd5:    return 4'd14;
            default: return 4'd12;
        endcase
    endfunction

    function automatic word_src_e slot_source(input logic [STEP_W-1:0] step);
        case (step)
            3'd0:    return SRC_PC_LO;
            3'd1:    return SRC_SR;
            3'd2:    return SRC_PC_HI;
            3'd3:    return SRC_IR;
            3'd4:    return SRC_IR;
            3'd5:    return SRC_FA_LO;
            default: return SRC_FA_HI;
        endcase
    endfunction

    function automatic logic [15:0] pick_word(input frame_ctx_t c, input word_src_e s);
        case (s)
            SRC_PC_LO: return c.pc[15:0];
            SRC_PC_HI: return c.pc[31:16];
            SRC_SR:    return c.sr;
            SRC_IR:    return c.ir;
            SRC_FA_LO: return c.fault[15:0];
            default:   return c.fault[31:16];
        endcase
    endfunction

endpackage

// File: rtl/afs_ctx_capture.sv
`timescale 1ns/1ps
module afs_ctx_capture
    import afs_pkg::*;
#(
    parameter int SP_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  frame_ctx_t      ctx_in,
    input  logic [SP_W-1:0] sp_in,
    output frame_ctx_t      ctx_q,
    output logic [SP_W-1:0] sp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            sp_q  <= '0;
        end else if (load) begin
            ctx_q <= ctx_in;
            sp_q  <= sp_in;
        end
    end

    // Captured context must not move unless a new frame is loaded.
    AST_CTX_HELD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ctx_q) && $stable(sp_q)); // R7

endmodule

// File: rtl/afs_step_ctr.sv
`timescale 1ns/1ps
module afs_step_ctr
    import afs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [STEP_W-1:0] step_q,
    output logic              last
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FRAME_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            step_q <= '0;
        end else if (inc && !last) begin
            step_q <= step_q + 1'b1;
        end
    end

    assign last = (step_q == LAST_STEP);

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        step_q <= LAST_STEP); // R2

endmodule

// File: rtl/afs_slot_mux.sv
`timescale 1ns/1ps
module afs_slot_mux
    import afs_pkg::*;
#(
    parameter int SP_W = 32
) (
    input  logic [STEP_W-1:0] step,
    input  frame_ctx_t        ctx,
    input  logic [SP_W-1:0]   sp,
    output logic [SP_W-1:0]   addr,
    output logic [15:0]       data
);

    always_comb begin
        addr = sp - SP_W'(slot_offset(step));
        data = pick_word(ctx, slot_source(step));
    end

endmodule

// File: rtl/addr_fault_frame_seq.sv
`timescale 1ns/1ps
module addr_fault_frame_seq
    import afs_pkg::*;
#(
    parameter int SP_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [31:0]     pc_i,
    input  logic [15:0]     sr_i,
    input  logic [15:0]     ir_i,
    input  logic [31:0]     fault_addr_i,
    input  logic [SP_W-1:0] ssp_i,
    input  logic            wr_ack_i,
    output logic            wr_en_o,
    output logic [SP_W-1:0] wr_addr_o,
    output logic [15:0]     wr_data_o,
    output logic [SP_W-1:0] ssp_o,
    output logic            done_o
);

    localparam logic [SP_W-1:0] FRAME_SPAN = SP_W'(FRAME_BYTES);

    seq_state_e        state_q;
    frame_ctx_t        ctx_in;
    frame_ctx_t        ctx_q;
    logic [SP_W-1:0]   sp_q;
    logic [SP_W-1:0]   ssp_q;
    logic [STEP_W-1:0] step_q;
    logic              step_last;
    logic              load;
    logic              accept;
    logic              finish;
    logic [SP_W-1:0]   frame_gap;

    assign ctx_in = '{pc: pc_i, sr: sr_i, ir: ir_i, fault: fault_addr_i};
    assign load   = (state_q == ST_IDLE) && start_i;
    assign accept = (state_q == ST_WRITE) && wr_ack_i;
    assign finish = accept && step_last;

    afs_ctx_capture #(.SP_W(SP_W)) ctx_i (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .ctx_in (ctx_in),
        .sp_in  (ssp_i),
        .ctx_q  (ctx_q),
        .sp_q   (sp_q)
    );

    afs_step_ctr ctr_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (load),
        .inc    (accept),
        .step_q (step_q),
        .last   (step_last)
    );

    afs_slot_mux #(.SP_W(SP_W)) mux_i (
        .step (step_q),
        .ctx  (ctx_q),
        .sp   (sp_q),
        .addr (wr_addr_o),
        .data (wr_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (start_i) state_q <= ST_WRITE;
                ST_WRITE: if (finish)  state_q <= ST_DONE;
                default:               state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ssp_q <= '0;
        end else if (finish) begin
            ssp_q <= sp_q - FRAME_SPAN;
        end
    end

    assign wr_en_o   = (state_q == ST_WRITE);
    assign done_o    = (state_q == ST_DONE);
    assign ssp_o     = ssp_q;
    assign frame_gap = sp_q - wr_addr_o;

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_en_o && !wr_ack_i |=> wr_en_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R5
    AST_DONE_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !wr_en_o); // R5
    AST_SSP_BELOW_LAST: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ssp_o == $past(wr_addr_o) - SP_W'(2)); // R6
    AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> frame_gap >= SP_W'(2) && frame_gap <= FRAME_SPAN && !frame_gap[0]); // R2

endmodule

// File: tb/addr_fault_frame_seq_tb_top.sv
`timescale 1ns/1ps
module addr_fault_frame_seq_tb_top;

    localparam int SP_W = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            start_i;
    logic [31:0]     pc_i;
    logic [15:0]     sr_i;
    logic [15:0]     ir_i;
    logic [31:0]     fault_addr_i;
    logic [SP_W-1:0] ssp_i;
    logic            wr_ack_i;
    logic            wr_en_o;
    logic [SP_W-1:0] wr_addr_o;
    logic [15:0]     wr_data_o;
    logic [SP_W-1:0] ssp_o;
    logic            done_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    addr_fault_frame_seq #(.SP_W(SP_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .pc_i(pc_i), .sr_i(sr_i),
        .ir_i(ir_i), .fault_addr_i(fault_addr_i), .ssp_i(ssp_i),
        .wr_ack_i(wr_ack_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .ssp_o(ssp_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] s, input int i);
        case (i)
            0: return s - 32'd2;
            1: return s - 32'd6;
            2: return s - 32'd4;
            3: return s - 32'd8;
            4: return s - 32'd10;
            5: return s - 32'd14;
            default: return s - 32'd12;
        endcase
    endfunction

    function automatic logic [15:0] exp_data(input logic [31:0] pc, input logic [15:0] sr,
                                             input logic [15:0] ir, input logic [31:0] fa, input int i);
        case (i)
            0: return pc[15:0];
            1: return sr;
            2: return pc[31:16];
            3: return ir;
            4: return ir;
            5: return fa[15:0];
            default: return fa[31:16];
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1; start_i = 1'b0; wr_ack_i = 1'b0;
        pc_i = '0; sr_i = '0; ir_i = '0; fault_addr_i = '0; ssp_i = '0;
        repeat (3) @(negedge clk);
        chk(wr_en_o == 1'b0, "R1 wr_en in reset", 32'(wr_en_o), 0);
        chk(done_o == 1'b0, "R1 done in reset", 32'(done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_en_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", 32'({wr_en_o, done_o}), 0);
        chk(ssp_o == '0, "R1 ssp after reset", ssp_o, 0);
    endtask

    // Runs one frame; wait cycles before ack at step i = (i * dly) % 3.
    task automatic run_frame(input logic [31:0] s, input logic [31:0] pc, input logic [15:0] sr,
                             input logic [15:0] ir, input logic [31:0] fa, input int dly,
                             input bit disturb, input string tag);
        ssp_i = s; pc_i = pc; sr_i = sr; ir_i = ir; fault_addr_i = fa;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 7; i++) begin
            int w;
            w = (i * dly) % 3;
            if (disturb && i == 2) w = 2;
            for (int k = 0; k < w; k++) begin
                chk(wr_en_o == 1'b1, {tag, " R4 wr_en held"}, 32'(wr_en_o), 1);
                chk(wr_addr_o == exp_addr(s, i), {tag, " R4 addr held"}, wr_addr_o, exp_addr(s, i));
                chk(wr_data_o == exp_data(pc, sr, ir, fa, i), {tag, " R4 data held"},
                    32'(wr_data_o), 32'(exp_data(pc, sr, ir, fa, i)));
                if (disturb && i == 2 && k == 0) begin
                    pc_i = ~pc; sr_i = ~sr; ir_i = ~ir; fault_addr_i = ~fa; ssp_i = s + 32'h100;
                    start_i = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
            start_i = 1'b0;
            chk(wr_en_o == 1'b1, {tag, " R2 wr_en"}, 32'(wr_en_o), 1);
            chk(wr_addr_o == exp_addr(s, i), {tag, " R2 addr"}, wr_addr_o, exp_addr(s, i));
            chk(wr_data_o == exp_data(pc, sr, ir, fa, i), {tag, " R3 data"},
                32'(wr_data_o), 32'(exp_data(pc, sr, ir, fa, i)));
            wr_ack_i = 1'b1;
            @(negedge clk);
            wr_ack_i = 1'b0;
        end
        chk(done_o == 1'b1, {tag, " R5 done pulse"}, 32'(done_o), 1);
        chk(wr_en_o == 1'b0, {tag, " R5 no write at done"}, 32'(wr_en_o), 0);
        chk(ssp_o == s - 32'd14, {tag, " R6 ssp"}, ssp_o, s - 32'd14);
        @(negedge clk);
        chk(done_o == 1'b0, {tag, " R5 done drops"}, 32'(done_o), 0);
        chk(wr_en_o == 1'b0, {tag, " R7 no queued frame"}, 32'(wr_en_o), 0);
        chk(ssp_o == s - 32'd14, {tag, " R6 ssp held"}, ssp_o, s - 32'd14);
        @(negedge clk);
        chk(wr_en_o == 1'b0, {tag, " R7 still idle"}, 32'(wr_en_o), 0);
    endtask

    task automatic t_worked_trace();
        run_frame(32'h004542AC, 32'h0070C606, 16'h2313, 16'hDBB3, 32'hE0368B61, 0, 1'b0, "trace");
    endtask

    task automatic t_slow_bus();
        run_frame(32'h00010000, 32'h12345678, 16'h2700, 16'h4E75, 32'h00ABCDEF, 1, 1'b0, "slow1");
        run_frame(32'h8000FF00, 32'hCAFEF00D, 16'h0004, 16'h3028, 32'hFFFF0001, 2, 1'b0, "slow2");
    endtask

    task automatic t_disturb();
        run_frame(32'h00002000, 32'hA5A55A5A, 16'h2015, 16'h0C79, 32'h00FE0013, 0, 1'b1, "R7 disturb");
    endtask

    task automatic t_wrap();
        run_frame(32'h00000006, 32'h00000100, 16'h2700, 16'h3010, 32'h00000003, 1, 1'b0, "R8 wrap");
        chk(ssp_o == 32'hFFFFFFF8, "R8 wrapped ssp", ssp_o, 32'hFFFFFFF8);
    endtask

    task automatic t_mid_reset();
        ssp_i = 32'h00005000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wr_ack_i = 1'b1;
        @(negedge clk);
        wr_ack_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_en_o == 1'b0, "R1 abandon on reset", 32'(wr_en_o), 0);
        chk(ssp_o == '0, "R1 ssp cleared", ssp_o, 0);
        chk(done_o == 1'b0, "R1 no done after abort", 32'(done_o), 0);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        t_worked_trace();
        t_slow_bus();
        t_disturb();
        t_wrap();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule